// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two single-precision (binary32) floating-point operands and returns a binary32 product together with three status flags. It is a fixed-latency pipeline that accepts a new operand pair on every clock. An operand pair is taken on a rising edge when `in_valid` is high. The product and its flags appear three rising edges later, marked by `out_valid`.

Each operand is split into sign (bit 31), biased exponent (bits 30..23) and fraction (bits 22..0), and is decoded into one of five classes:

- **Zero:** exponent 0x00 and fraction 0.
- **Subnormal:** exponent 0x00 and a nonzero fraction. The hidden bit is 0 and the effective exponent is 1.
- **Normal:** exponent 0x01..0xFE. The hidden bit is 1.
- **Infinity:** exponent 0xFF and fraction 0.
- **NaN:** exponent 0xFF and a nonzero fraction.

The 24-bit significands are multiplied into a 48-bit product, and the exponents are added with the bias removed. A leading-one search normalizes the product. Rounding is round-to-nearest, ties-to-even. The result is then range-checked and packed. Special classes bypass the arithmetic path.

Top module: `fpm_mul`

## Requirements
- R1: After reset, `out_valid`, `out_result` and all flags are 0. Each accepted pair produces exactly one `out_valid` pulse three rising edges after it is taken, and results leave in the order the pairs arrived. A cycle with `in_valid` low produces no output.
- R2: The result sign (bit 31) is the XOR of the operand signs for every non-NaN result.
- R3: When the significand product is 2.0 or larger, the result fraction is taken one place lower and the exponent is one higher (for example, 1.5 × 1.5 = 0x40100000).
- R4: Rounding is to nearest using the guard bit and the sticky OR of all lower product bits. An exact tie rounds to the even fraction: 0x3F800001 × 0x3FC00000 = 0x3FC00002, and 0x3F800003 × 0x3FC00000 = 0x3FC00004.
- R5: When rounding carries out of the significand, the fraction becomes 0 and the exponent rises by one (0x3F800001 × 0x3FFFFFFE = 0x40000000).
- R6: A subnormal operand uses hidden bit 0 and exponent 1. Its product is renormalized by the leading one, so 0x00000001 × 0x4B000000 = 0x00800000.
- R7: A zero operand times a finite operand gives a zero of the XOR sign, with no flags set.
- R8: An infinite operand times a finite nonzero operand gives an infinity of the XOR sign, with no flags set.
- R9: A biased exponent above 254 after rounding gives an infinity of the XOR sign (exponent 0xFF, fraction 0) and sets `out_overflow`.
- R10: A biased exponent below 1 after rounding gives a zero of the XOR sign and sets `out_underflow`.
- R11: A NaN operand, or infinity times zero, gives 0x7FC00000 and sets `out_invalid`.
- R12: At most one flag is set with any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First binary32 operand |
| in_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Binary32 product |
| out_overflow | output | 1 | Result saturated to infinity |
| out_underflow | output | 1 | Result flushed to zero |
| out_invalid | output | 1 | Result is the quiet NaN |

## Verification
A wrong stage-valid bit shows at the ports as a missing, extra or shifted `out_valid` pulse, exactly three edges after the pair that caused it. A wrong special-case code or class decode shows as a wrong value or flag on that same pulse. Errors in the product, normalization shift or round increment appear as a one-ulp or one-exponent mismatch in the packed result. These are exposed only by operands placed at ties, carries and range edges. Back-to-back pairs with idle gaps between them show whether in-flight results ever mix.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fpm_cls_e;

    typedef enum logic [1:0] {
        SP_NONE,
        SP_ZERO,
        SP_INF,
        SP_QNAN
    } fpm_special_e;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output fpm_cls_e              cls,
    output logic                  sgn,
    output logic [EXP_W-1:0]      eff_exp,
    output logic [FRAC_W:0]       sig
);
    localparam int W = EXP_W + FRAC_W + 1;

    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign sgn = op[W-1];
    assign ex  = op[W-2:FRAC_W];
    assign fr  = op[FRAC_W-1:0];

    always_comb begin
        if (ex == '0)
            cls = (fr == '0) ? CLS_ZERO : CLS_SUB;
        else if (ex == '1)
            cls = (fr == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NORM;
    end

    // subnormals share exponent 1 with the smallest normal, hidden bit 0
    assign eff_exp = (ex == '0) ? EXP_W'(1) : ex;
    assign sig     = {(ex != '0), fr};
endmodule

// File: rtl/fpm_normround.sv
module fpm_normround #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      sgn,
    input  logic [EXP_W:0]            esum,
    input  logic [2*(FRAC_W+1)-1:0]   prod,
    output logic [EXP_W+FRAC_W:0]     res,
    output logic                      ovf,
    output logic                      unf
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int LZ_W   = $clog2(PROD_W);
    localparam int E_W    = EXP_W + 4;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int OFFS   = BIAS + 2 * FRAC_W;
    localparam logic signed [E_W-1:0] EMAX = E_W'((1 << EXP_W) - 2);

    logic [LZ_W-1:0]         lead;
    logic [LZ_W-1:0]         shamt;
    logic [PROD_W-1:0]       q;
    logic [SIG_W-1:0]        mant;
    logic                    guard, sticky, rinc;
    logic [SIG_W:0]          msum;
    logic signed [E_W-1:0]   e_fin;
    logic [FRAC_W-1:0]       frac;

    // leading-one position, highest set bit wins
    always_comb begin
        lead = '0;
        for (int i = 0; i < PROD_W; i++)
            if (prod[i]) lead = LZ_W'(i);
    end

    assign shamt  = LZ_W'(PROD_W - 1) - lead;
    assign q      = prod << shamt;
    assign mant   = q[PROD_W-1 -: SIG_W];
    assign guard  = q[PROD_W-1-SIG_W];
    assign sticky = |q[PROD_W-2-SIG_W:0];
    assign rinc   = guard & (sticky | mant[0]);
    assign msum   = {1'b0, mant} + (SIG_W+1)'(rinc);
    assign frac   = msum[SIG_W] ? '0 : msum[FRAC_W-1:0];

    assign e_fin = E_W'(esum) - E_W'(OFFS) + E_W'(lead) + E_W'(msum[SIG_W]);

    assign ovf = (e_fin > EMAX);
    assign unf = e_fin[E_W-1] | (e_fin == '0);

    always_comb begin
        if (ovf)
            res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (unf)
            res = {sgn, {(EXP_W+FRAC_W){1'b0}}};
        else
            res = {sgn, e_fin[EXP_W-1:0], frac};
    end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    output logic        out_valid,
    output logic [31:0] out_result,
    output logic        out_overflow,
    output logic        out_underflow,
    output logic        out_invalid
);
    localparam int W      = EXP_W + FRAC_W + 1;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    // ---- stage 0: classify ----
    fpm_cls_e          cls_a, cls_b;
    logic              sg_a, sg_b;
    logic [EXP_W-1:0]  ex_a, ex_b;
    logic [SIG_W-1:0]  sig_a, sig_b;
    fpm_special_e      sp_d;

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .op(in_a[W-1:0]), .cls(cls_a), .sgn(sg_a), .eff_exp(ex_a), .sig(sig_a));
    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .op(in_b[W-1:0]), .cls(cls_b), .sgn(sg_b), .eff_exp(ex_b), .sig(sig_b));

    always_comb begin
        if (cls_a == CLS_NAN || cls_b == CLS_NAN ||
            (cls_a == CLS_INF && cls_b == CLS_ZERO) ||
            (cls_a == CLS_ZERO && cls_b == CLS_INF))
            sp_d = SP_QNAN;
        else if (cls_a == CLS_INF || cls_b == CLS_INF)
            sp_d = SP_INF;
        else if (cls_a == CLS_ZERO || cls_b == CLS_ZERO)
            sp_d = SP_ZERO;
        else
            sp_d = SP_NONE;
    end

    logic              s1_vld, s1_sgn;
    logic [EXP_W-1:0]  s1_ea, s1_eb;
    logic [SIG_W-1:0]  s1_ma, s1_mb;
    fpm_special_e      s1_sp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_sgn <= 1'b0;
            s1_ea  <= '0;
            s1_eb  <= '0;
            s1_ma  <= '0;
            s1_mb  <= '0;
            s1_sp  <= SP_NONE;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_sgn <= sg_a ^ sg_b;
                s1_ea  <= ex_a;
                s1_eb  <= ex_b;
                s1_ma  <= sig_a;
                s1_mb  <= sig_b;
                s1_sp  <= sp_d;
            end
        end
    end

    // ---- stage 1: multiply significands, add exponents ----
    logic              s2_vld, s2_sgn;
    logic [EXP_W:0]    s2_esum;
    logic [PROD_W-1:0] s2_prod;
    fpm_special_e      s2_sp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_sgn  <= 1'b0;
            s2_esum <= '0;
            s2_prod <= '0;
            s2_sp   <= SP_NONE;
        end else begin
            s2_vld <= s1_vld;
            if (s1_vld) begin
                s2_sgn  <= s1_sgn;
                s2_esum <= {1'b0, s1_ea} + {1'b0, s1_eb};
                s2_prod <= PROD_W'(s1_ma) * PROD_W'(s1_mb);
                s2_sp   <= s1_sp;
            end
        end
    end

    // ---- stage 2: normalize, round, pack, override ----
    logic [W-1:0] nr_res;
    logic         nr_ovf, nr_unf;

    fpm_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normround (
        .sgn(s2_sgn), .esum(s2_esum), .prod(s2_prod),
        .res(nr_res), .ovf(nr_ovf), .unf(nr_unf));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_overflow  <= 1'b0;
            out_underflow <= 1'b0;
            out_invalid   <= 1'b0;
        end else begin
            out_valid <= s2_vld;
            if (s2_vld) begin
                unique case (s2_sp)
                    SP_QNAN: begin
                        out_result    <= 32'(QNAN);
                        out_overflow  <= 1'b0;
                        out_underflow <= 1'b0;
                        out_invalid   <= 1'b1;
                    end
                    SP_INF: begin
                        out_result    <= 32'({s2_sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}});
                        out_overflow  <= 1'b0;
                        out_underflow <= 1'b0;
                        out_invalid   <= 1'b0;
                    end
                    SP_ZERO: begin
                        out_result    <= 32'({s2_sgn, {(W-1){1'b0}}});
                        out_overflow  <= 1'b0;
                        out_underflow <= 1'b0;
                        out_invalid   <= 1'b0;
                    end
                    default: begin
                        out_result    <= 32'(nr_res);
                        out_overflow  <= nr_ovf;
                        out_underflow <= nr_unf;
                        out_invalid   <= 1'b0;
                    end
                endcase
            end
        end
    end

    // ---- assertions ----
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 (out_invalid || out_result[31] == $past(in_a[31] ^ in_b[31], 3)));

    a_r9_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> (out_result[30:0] == 31'h7F80_0000));

    a_r10_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_underflow) |-> (out_result[30:0] == 31'h0));

    a_r11_invalid_qnan: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |-> (out_result == 32'h7FC0_0000));

    a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({out_overflow, out_underflow, out_invalid}));
endmodule

// File: tb/fpm_mul_bench.sv
module fpm_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_overflow, out_underflow, out_invalid;

    always #2 clk = ~clk;

    fpm_mul u_fpm_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .out_overflow(out_overflow),
        .out_underflow(out_underflow), .out_invalid(out_invalid));

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        logic        unf;
        logic        inv;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    task automatic push(input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] r, input logic ov, input logic un,
                        input logic iv, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        e.res = r; e.ovf = ov; e.unf = un; e.inv = iv; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = 32'h7F80_0001;   // NaN garbage must not emerge (R1)
            in_b = 32'h0000_0000;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected output %08h, expected no output", out_result);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_result !== e.res || out_overflow !== e.ovf ||
                    out_underflow !== e.unf || out_invalid !== e.inv) begin
                    n_fail++;
                    $display("FAIL %s: got %08h o%0b u%0b i%0b, expected %08h o%0b u%0b i%0b",
                             e.req, out_result, out_overflow, out_underflow, out_invalid,
                             e.res, e.ovf, e.unf, e.inv);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_checks++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_overflow !== 1'b0 ||
            out_underflow !== 1'b0 || out_invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset outputs v%0b %08h, expected v0 00000000",
                     out_valid, out_result);
        end
        rst_n = 1'b1;
        idle(2);

        // back-to-back stream
        push(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 0, 0, 0, "R1");
        push(32'h4000_0000, 32'h4040_0000, 32'h40C0_0000, 0, 0, 0, "R1");
        push(32'hC000_0000, 32'h4040_0000, 32'hC0C0_0000, 0, 0, 0, "R2");
        push(32'h3FC0_0000, 32'h3FC0_0000, 32'h4010_0000, 0, 0, 0, "R3");
        push(32'h3F80_0001, 32'h3F80_0001, 32'h3F80_0002, 0, 0, 0, "R4");
        push(32'h3F80_0001, 32'h3FC0_0000, 32'h3FC0_0002, 0, 0, 0, "R4");
        push(32'h3F80_0003, 32'h3FC0_0000, 32'h3FC0_0004, 0, 0, 0, "R4");
        push(32'h3F80_0001, 32'h3FFF_FFFE, 32'h4000_0000, 0, 0, 0, "R5");
        idle(3);
        push(32'h0000_0001, 32'h4B00_0000, 32'h0080_0000, 0, 0, 0, "R6");
        push(32'h0040_0000, 32'h4000_0000, 32'h0080_0000, 0, 0, 0, "R6");
        push(32'h0000_0000, 32'h40A0_0000, 32'h0000_0000, 0, 0, 0, "R7");
        idle(1);
        push(32'h8000_0000, 32'h40A0_0000, 32'h8000_0000, 0, 0, 0, "R7");
        push(32'h7F80_0000, 32'hC000_0000, 32'hFF80_0000, 0, 0, 0, "R8");
        push(32'h7F00_0000, 32'h4000_0000, 32'h7F80_0000, 1, 0, 0, "R9");
        push(32'hFF00_0000, 32'h4000_0000, 32'hFF80_0000, 1, 0, 0, "R9");
        push(32'h0080_0000, 32'h3F00_0000, 32'h0000_0000, 0, 1, 0, "R10");
        push(32'h8080_0000, 32'h3F00_0000, 32'h8000_0000, 0, 1, 0, "R10");
        push(32'h0040_0000, 32'h0040_0000, 32'h0000_0000, 0, 1, 0, "R10");
        push(32'h7F80_0000, 32'h0000_0000, 32'h7FC0_0000, 0, 0, 1, "R11");
        push(32'hBF80_0000, 32'h7F80_0001, 32'h7FC0_0000, 0, 0, 1, "R11");
        push(32'hFFC0_0000, 32'h7F80_0000, 32'h7FC0_0000, 0, 0, 1, "R12");
        idle(8);

        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R1: %0d results missing, expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule